// File: doc/BRIEF.md
# Dual-Coding Asynchronous Frame Receiver

This block turns a single serial line into parallel characters. The line can use plain level coding (NRZ) or Manchester coding, chosen by a static mode input. A 16x oversampling tick paces the receiver, and every bit cell lasts 16 ticks. The receiver waits for a start cell. It then collects 5 to 9 data bits, least significant bit first. In NRZ mode it can check an even or odd parity bit. It then reads one or two stop cells and presents the whole character with one strobe. The character comes with the stop values it captured and three error flags: parity, framing and coding.

The start cell is a plain low level in both modes. In Manchester mode every later cell carries its value in the direction of the transition at its centre. A low-to-high transition means 1 and a high-to-low transition means 0. Manchester frames never carry a parity cell. The receiver reports the decoded value of each stop cell instead of only checking it.

The control is one state machine with these states:
- IDLE: waits for a low line on a tick.
- START: checks the start cell at its middle.
- DATA: collects the data bits.
- PARITY: holds the NRZ parity cell.
- STOP1 and STOP2: hold the stop cells.
- DONE: a one-clock strobe state.

The transitions are:
- IDLE→START on a low line at a tick.
- START→IDLE when the line is high at count 8.
- START→DATA at the end of the start cell.
- DATA→PARITY after the last data bit, in NRZ mode with parity on.
- DATA→STOP1 after the last data bit otherwise.
- PARITY→STOP1 at the end of the parity cell.
- STOP1→STOP2 at the end of the cell when two stop cells are configured.
- STOP1→DONE at the end of the cell otherwise.
- STOP2→DONE at the end of the cell.
- DONE→START when a new start is seen on that clock.
- DONE→IDLE otherwise.

Top module: `mrx_frame_rx`

## Requirements
- R1: A tick with the line low in IDLE or DONE begins a frame, and that tick is count 0 of the start cell. If the line is high at the tick of count 8, the frame is abandoned without a strobe. The receiver then waits for the next low line.
- R2: In NRZ mode each cell is sampled at the ticks of counts 7, 8 and 9, and the majority of the three samples is the bit value. A single inverted sample at count 8 does not change the bit.
- R3: The data length input `cfg_len` is the bit count 5 to 9. Values below 5 act as 5 and values above 9 act as 9. Bits are received LSB first into `out_data[0]` upward, and the bits above the length read 0.
- R4: In NRZ mode `cfg_par` works as follows: 0x means no parity cell, 10 means even parity and 11 means odd parity. With parity on, the cell after the last data bit is compared with the XOR of the data bits, inverted for odd parity. A mismatch sets `out_par_err`.
- R5: In Manchester mode each data and stop cell is sampled at counts 4 and 12. A low-then-high cell decodes as 1 and a high-then-low cell decodes as 0.
- R6: In Manchester mode a cell whose two half samples are equal sets `out_code_err`, and the second-half sample is taken as the bit. In NRZ mode `out_code_err` is always 0.
- R7: In Manchester mode there is no parity cell whatever `cfg_par` holds. The cell after the last data bit is the first stop cell, and `out_par_err` is 0.
- R8: In Manchester mode the decoded value of the first stop cell is `out_stop[0]`. The decoded value of the second stop cell is `out_stop[1]` when two stop cells are configured; otherwise `out_stop[1]` is 0.
- R9: In NRZ mode with two stop cells, the receiver waits out the second stop cell without examining it. `out_stop[1]` is 0, and a low second stop cell neither flags an error nor starts a frame.
- R10: A first stop cell read as 0 sets `out_frm_err`. The character is still delivered with its strobe, and `out_stop[0]` holds the 0.
- R11: `out_valid` is high for exactly one clock after the tick that ends the last cell of a frame. The fields stay unchanged until the next start is detected.
- R12: After reset `out_valid`, `out_data`, `out_stop` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, one clock wide, 16 per bit cell |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 4 | Data bit count (5..9, clamped) |
| cfg_par | input | 2 | Parity: 0x none, 10 even, 11 odd (NRZ only) |
| cfg_two_stop | input | 1 | 1 selects two stop cells |
| cfg_manch | input | 1 | 1 selects Manchester coding, 0 NRZ |
| out_valid | output | 1 | One-clock character strobe |
| out_data | output | 9 | Received character, upper unused bits 0 |
| out_stop | output | 2 | Captured stop values |
| out_par_err | output | 1 | Parity mismatch |
| out_frm_err | output | 1 | First stop cell read as 0 |
| out_code_err | output | 1 | Manchester cell without a centre transition |

## Verification
Random frames mix every length, parity mode, stop count, coding mode, data value and stop value. This separates faults in bit ordering, masking and the choice of state path. Injected faults distinguish the error flags from one another: a flipped parity cell, a Manchester cell without a transition, a zero stop cell, and a low second stop in NRZ. A one-tick glitch at the middle sample tells majority voting apart from single sampling. A short low pulse shows that a false start is dropped, and out-of-range lengths show the clamp.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2,
        ST_DONE
    } rx_state_t;

    localparam int MIN_BITS = 5;
    localparam int PAR_EN_BIT = 1;
    localparam int PAR_ODD_BIT = 0;
endpackage

// File: rtl/mrx_cell_timer.sv
module mrx_cell_timer #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic active,
    input  logic manch,
    input  logic rxd,
    output logic cell_end,
    output logic mid_tick,
    output logic bit_val,
    output logic halves_equal
);
    localparam int OVS = 1 << CNT_W;
    localparam logic [CNT_W-1:0] MID    = CNT_W'(OVS / 2);
    localparam logic [CNT_W-1:0] PRE    = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] POST   = CNT_W'(OVS / 2 + 1);
    localparam logic [CNT_W-1:0] HALF_A = CNT_W'(OVS / 4);
    localparam logic [CNT_W-1:0] HALF_B = CNT_W'(3 * OVS / 4);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(OVS - 1);

    logic [CNT_W-1:0] cnt;
    logic smp_a, smp_b, smp_c, half_lo, half_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= CNT_W'(1);
        end else if (!active) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_a   <= 1'b1;
            smp_b   <= 1'b1;
            smp_c   <= 1'b1;
            half_lo <= 1'b1;
            half_hi <= 1'b1;
        end else if (tick && active) begin
            if (cnt == PRE)    smp_a   <= rxd;
            if (cnt == MID)    smp_b   <= rxd;
            if (cnt == POST)   smp_c   <= rxd;
            if (cnt == HALF_A) half_lo <= rxd;
            if (cnt == HALF_B) half_hi <= rxd;
        end
    end

    assign cell_end     = tick && active && (cnt == LAST);
    assign mid_tick     = tick && active && (cnt == MID);
    assign halves_equal = (half_lo == half_hi);
    assign bit_val      = manch ? half_hi
                                : ((smp_a & smp_b) | (smp_a & smp_c) | (smp_b & smp_c));
endmodule

// File: rtl/mrx_parity.sv
module mrx_parity #(
    parameter int MAX_BITS = 9
) (
    input  logic [MAX_BITS-1:0] data,
    input  logic                odd,
    output logic                expected
);
    assign expected = (^data) ^ odd;
endmodule

// File: rtl/mrx_frame_rx.sv
module mrx_frame_rx
    import mrx_pkg::*;
#(
    parameter int MAX_BITS = 9,
    parameter int CNT_W    = 4,
    parameter int LEN_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rxd,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [1:0]          cfg_par,
    input  logic                cfg_two_stop,
    input  logic                cfg_manch,
    output logic                out_valid,
    output logic [MAX_BITS-1:0] out_data,
    output logic [1:0]          out_stop,
    output logic                out_par_err,
    output logic                out_frm_err,
    output logic                out_code_err
);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_BITS);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BITS);

    rx_state_t state, state_nx;

    logic [LEN_W-1:0]    eff_len, last_idx, bit_idx;
    logic [MAX_BITS-1:0] data_q;
    logic [1:0]          stop_q;
    logic                perr_q, ferr_q, cerr_q;
    logic                waiting, start_seen, active;
    logic                cell_end, mid_tick, bit_val, halves_equal, par_exp;
    logic                par_on;

    assign eff_len    = (cfg_len < LEN_MIN) ? LEN_MIN :
                        (cfg_len > LEN_MAX) ? LEN_MAX : cfg_len;
    assign last_idx   = eff_len - 1'b1;
    assign waiting    = (state == ST_IDLE) || (state == ST_DONE);
    assign start_seen = waiting && os_tick && !rxd;
    assign active     = !waiting;
    assign par_on     = cfg_par[PAR_EN_BIT] && !cfg_manch;

    mrx_cell_timer #(.CNT_W(CNT_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (os_tick),
        .restart      (start_seen),
        .active       (active),
        .manch        (cfg_manch),
        .rxd          (rxd),
        .cell_end     (cell_end),
        .mid_tick     (mid_tick),
        .bit_val      (bit_val),
        .halves_equal (halves_equal)
    );

    mrx_parity #(.MAX_BITS(MAX_BITS)) u_parity (
        .data     (data_q),
        .odd      (cfg_par[PAR_ODD_BIT]),
        .expected (par_exp)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE: state_nx = start_seen ? ST_START : ST_IDLE;
            ST_START: begin
                if (mid_tick && rxd)  state_nx = ST_IDLE;
                else if (cell_end)    state_nx = ST_DATA;
            end
            ST_DATA:
                if (cell_end && bit_idx == last_idx)
                    state_nx = par_on ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (cell_end) state_nx = ST_STOP1;
            ST_STOP1:  if (cell_end) state_nx = cfg_two_stop ? ST_STOP2 : ST_DONE;
            ST_STOP2:  if (cell_end) state_nx = ST_DONE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            stop_q  <= '0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            cerr_q  <= 1'b0;
            bit_idx <= '0;
        end else if (start_seen) begin
            data_q  <= '0;
            stop_q  <= '0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            cerr_q  <= 1'b0;
            bit_idx <= '0;
        end else if (cell_end) begin
            unique case (state)
                ST_DATA: begin
                    data_q[bit_idx] <= bit_val;
                    bit_idx         <= bit_idx + 1'b1;
                    if (cfg_manch && halves_equal) cerr_q <= 1'b1;
                end
                ST_PARITY: perr_q <= (bit_val != par_exp);
                ST_STOP1: begin
                    stop_q[0] <= bit_val;
                    ferr_q    <= !bit_val;
                    if (cfg_manch && halves_equal) cerr_q <= 1'b1;
                end
                ST_STOP2: begin
                    if (cfg_manch) begin
                        stop_q[1] <= bit_val;
                        if (halves_equal) cerr_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        out_valid    = (state == ST_DONE);
        out_data     = data_q;
        out_stop     = stop_q;
        out_par_err  = perr_q;
        out_frm_err  = ferr_q;
        out_code_err = cerr_q;
    end
endmodule

// File: rtl/mrx_frame_rx_chk.sv
module mrx_frame_rx_chk #(
    parameter int MAX_BITS = 9,
    parameter int LEN_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [LEN_W-1:0]    cfg_len,
    input logic                cfg_manch,
    input logic                out_valid,
    input logic [MAX_BITS-1:0] out_data,
    input logic [1:0]          out_stop,
    input logic                out_par_err,
    input logic                out_frm_err,
    input logic                out_code_err
);
    AST_STROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R11
    AST_MANCH_NO_PARITY: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && cfg_manch) |-> !out_par_err); // R7
    AST_NRZ_STOP2_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !cfg_manch) |-> !out_stop[1]); // R9
    AST_FRAME_ERR_MATCH: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_frm_err == !out_stop[0])); // R10
    AST_NRZ_NO_CODE_ERR: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !cfg_manch) |-> !out_code_err); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && cfg_len <= LEN_W'(5)) |-> (out_data[MAX_BITS-1:5] == '0)); // R3
endmodule

bind mrx_frame_rx mrx_frame_rx_chk #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_len      (cfg_len),
    .cfg_manch    (cfg_manch),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_stop     (out_stop),
    .out_par_err  (out_par_err),
    .out_frm_err  (out_frm_err),
    .out_code_err (out_code_err)
);

// File: tb/tb_mrx_frame_rx.sv
module tb_mrx_frame_rx;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [3:0] cfg_len = 4'd8;
    logic [1:0] cfg_par = 2'b00;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_manch = 1'b0;
    logic       out_valid;
    logic [8:0] out_data;
    logic [1:0] out_stop;
    logic       out_par_err, out_frm_err, out_code_err;

    int n_checks = 0;
    int n_fail   = 0;
    int n_frames = 0;
    int double_strobe = 0;
    logic prev_valid = 1'b0;
    logic [8:0] cap_data;
    logic [1:0] cap_stop;
    logic cap_perr, cap_ferr, cap_cerr;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mrx_frame_rx dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop),
        .cfg_manch(cfg_manch), .out_valid(out_valid), .out_data(out_data),
        .out_stop(out_stop), .out_par_err(out_par_err),
        .out_frm_err(out_frm_err), .out_code_err(out_code_err)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            n_frames++;
            cap_data = out_data;
            cap_stop = out_stop;
            cap_perr = out_par_err;
            cap_ferr = out_frm_err;
            cap_cerr = out_code_err;
            if (prev_valid) double_strobe++;
        end
        prev_valid = out_valid;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff_len(logic [3:0] l);
        if (l < 4'd5) return 5;
        if (l > 4'd9) return 9;
        return int'(l);
    endfunction

    function automatic logic exp_par(logic [8:0] d, int len, logic odd);
        logic p = odd;
        for (int i = 0; i < len; i++) p ^= d[i];
        return p;
    endfunction

    task automatic tick_once();
        @(negedge clk); os_tick = 1'b1;
        @(negedge clk); os_tick = 1'b0;
    endtask

    task automatic idle_ticks(int n);
        rxd = 1'b1;
        for (int i = 0; i < n; i++) tick_once();
    endtask

    task automatic cell_nrz(logic v, int glitch_at);
        for (int t = 0; t < 16; t++) begin
            rxd = (t == glitch_at) ? ~v : v;
            tick_once();
        end
    endtask

    task automatic cell_man(logic b, bit flat);
        rxd = flat ? b : ~b;
        for (int t = 0; t < 8; t++) tick_once();
        rxd = b;
        for (int t = 0; t < 8; t++) tick_once();
    endtask

    task automatic run_frame(logic [8:0] d, logic [3:0] len_cfg, logic [1:0] par,
                             logic two, logic man, logic s0, logic s1,
                             bit bad_par, bit flat0, bit glitch);
        int len = eff_len(len_cfg);
        int n0 = n_frames;
        logic [8:0] dm = d & 9'((1 << len) - 1);
        logic [1:0] e_stop;
        cfg_len = len_cfg; cfg_par = par; cfg_two_stop = two; cfg_manch = man;
        idle_ticks(4);
        cell_nrz(1'b0, -1);
        for (int i = 0; i < len; i++) begin
            if (man) cell_man(d[i], flat0 && i == 0);
            else     cell_nrz(d[i], (glitch && i == 1) ? 8 : -1);
        end
        if (!man && par[1]) cell_nrz(exp_par(d, len, par[0]) ^ bad_par, -1);
        if (man) cell_man(s0, 1'b0); else cell_nrz(s0, -1);
        if (two) begin
            if (man) cell_man(s1, 1'b0); else cell_nrz(s1, -1);
        end
        idle_ticks(6);
        e_stop = man ? {two ? s1 : 1'b0, s0} : {1'b0, s0};
        chk("R11 one strobe per frame", n_frames - n0, 1);
        chk(man ? "R5 manchester data" : (glitch ? "R2 majority data" : "R3 data"), cap_data, dm);
        chk(man ? "R8 stop capture" : "R9 nrz stop", cap_stop, e_stop);
        chk(man ? "R7 no parity in manchester" : "R4 parity flag", cap_perr, !man && par[1] && bad_par);
        chk("R10 framing flag", cap_ferr, !s0);
        chk("R6 coding flag", cap_cerr, man && flat0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R12 reset valid", out_valid, 0);
        chk("R12 reset data", out_data, 0);
        chk("R12 reset flags", {out_stop, out_par_err, out_frm_err, out_code_err}, 0);
        rst_n = 1'b1;
        idle_ticks(4);

        // R1: short low pulse is dropped, then a good frame is received
        begin
            int n0 = n_frames;
            rxd = 1'b0;
            for (int i = 0; i < 6; i++) tick_once();
            idle_ticks(40);
            chk("R1 false start", n_frames - n0, 0);
        end
        run_frame(9'h0A5, 4'd8, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 0, 0, 0);

        // directed corner cases
        run_frame(9'h1FF, 4'd5, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 0, 0, 0); // R3 upper bits zero
        run_frame(9'h1FF, 4'd2, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 0, 0, 0); // R3 clamp low
        run_frame(9'h155, 4'd14, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 0, 0, 0); // R3 clamp high
        run_frame(9'h03C, 4'd7, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1, 0, 0); // R4 odd mismatch
        run_frame(9'h03C, 4'd7, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1, 0, 0); // R4 even mismatch
        run_frame(9'h0F0, 4'd8, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 0, 0, 1); // R2 glitch
        run_frame(9'h066, 4'd8, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 0, 0, 0); // R9 low second stop
        run_frame(9'h081, 4'd8, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0, 0); // R10 low stop
        run_frame(9'h12D, 4'd9, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 0, 0, 0); // R7 R8 parity ignored
        run_frame(9'h0B2, 4'd8, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1, 0); // R6 flat cell
        run_frame(9'h01B, 4'd6, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 0, 0, 0); // R10 manchester

        // constrained random frames
        for (int k = 0; k < 40; k++) begin
            logic man = 1'($urandom);
            logic [1:0] par = 2'($urandom);
            run_frame(9'($urandom), 4'(5 + $urandom % 5), par, 1'($urandom), man,
                      1'($urandom % 4 != 0), 1'($urandom),
                      (!man && par[1] && ($urandom % 3 == 0)),
                      (man && ($urandom % 4 == 0)),
                      (!man && ($urandom % 3 == 0)));
        end

        chk("R11 strobe width", double_strobe, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule